// File: doc/BRIEF.md
# Prescaled Reference-Compare Interval Timer

This block is a 16-bit general-purpose timer for generating periodic tick interrupts. One of four count sources is chosen: stopped, the system clock, the system clock divided by a fixed amount, or rising edges on an external count pin. That source passes through an 8-bit prescaler and then drives a counter. The counter is compared with a programmable reference value. On a match the block sets an event flag, optionally raises an interrupt, drives its output pin, and either restarts from zero or keeps running and wraps at 16 bits.

A second input records the counter value into a capture register on a chosen edge. Software uses a small register bus to program the block. It writes the mode word and the reference, reads the counter and the capture value, and clears event flags by writing ones to them. The interrupt request stays high until software clears the flag that caused it.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero, and both `irq` and `tmr_out` are low.
- R2: The counter advances once for every N pulses of the selected source. N is mode bits [15:8], and a value of 0 means 256.
- R3: Mode bits [2:1] select the count source: 00 stopped, 01 every clock, 10 one pulse per 16 clocks, 11 a synchronized rising edge on `cnt_pin`.
- R4: With mode bit 3 set (restart), the counter steps through 0 to ref-1. On the step that would reach the reference it returns to 0.
- R5: With mode bit 3 clear (free run), the counter reaches the reference, continues past it, and wraps from 0xFFFF to 0.
- R6: A reference match sets event bit 0 (REF). That flag drives `irq` only when mode bit 4 is 1.
- R7: Writing a 1 to a bit of the event register at offset 4 clears that flag, and `irq` then drops.
- R8: Mode bits [7:6] choose the capture edge on `cap_pin`: 00 off, 01 rising, 10 falling, 11 both. A capture copies the counter into the capture register at offset 2 and sets event bit 1 (CAP). That flag drives `irq` while the capture edge field is non-zero.
- R9: With mode bit 5 set, `tmr_out` toggles on each match. With bit 5 clear, it is high for exactly one clock after each match.
- R10: While mode bit 0 (enable) is 0, the prescaler and counter are held at zero.
- R11: The mode register (offset 0) and the reference register (offset 1) read back what was written. Any write to offset 3 clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register offset: 0 mode, 1 reference, 2 capture, 3 counter, 4 events |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cap_pin | input | 1 | Asynchronous capture input |
| cnt_pin | input | 1 | Asynchronous external count input |
| tmr_out | output | 1 | Match output, pulse or toggle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer and a fixed slow divider of 16. These defaults keep the divide-by-16 source, the prescale-of-zero case (256 clocks) and a full 16-bit free-run wrap within a run of about seventy thousand clocks. Every check is timed from the clock edge at which a mode write takes effect, so the exact cycle of each counter step and each match is predicted. Capture checks are made while the count source is stopped. The captured value is therefore fixed regardless of synchronizer latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CNT_W = 16;
  localparam int BUS_W = 16;
  localparam int PS_W  = 8;
  localparam int PCNT_W = PS_W + 1;

  typedef enum logic [2:0] {
    OFS_MODE = 3'd0,
    OFS_REF  = 3'd1,
    OFS_CAP  = 3'd2,
    OFS_CNT  = 3'd3,
    OFS_EVT  = 3'd4
  } tmr_ofs_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_SLOW = 2'b10,
    SRC_PIN  = 2'b11
  } tmr_src_e;

  // field order is the software-visible bit layout, MSB first
  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic [1:0]      cedge;
    logic            toggle;
    logic            ref_ie;
    logic            restart;
    logic [1:0]      src;
    logic            enable;
  } tmr_mode_t;

  // divide ratio from the prescale field; zero stands for the full range
  function automatic logic [PCNT_W-1:0] presc_ratio(input logic [PS_W-1:0] ps);
    return (ps == '0) ? PCNT_W'(1 << PS_W) : PCNT_W'(ps);
  endfunction

  // capture qualifier from the edge field and the two detected edges
  function automatic logic cap_hit(input logic [1:0] ce, input logic rise, input logic fall);
    return (ce[0] & rise) | (ce[1] & fall);
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic prev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
endmodule

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
  import tmr_pkg::*;
#(
  parameter int SLOW_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      src,
  input  logic [PS_W-1:0] presc,
  input  logic            pin_rise,
  output logic            tick
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [SW-1:0]     slow_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] ratio;
  logic              slow_pulse;
  logic              src_pulse;

  assign slow_pulse = (slow_q == SW'(SLOW_DIV - 1));
  assign ratio      = presc_ratio(presc);

  always_comb begin
    unique case (tmr_src_e'(src))
      SRC_OFF:  src_pulse = 1'b0;
      SRC_SYS:  src_pulse = 1'b1;
      SRC_SLOW: src_pulse = slow_pulse;
      SRC_PIN:  src_pulse = pin_rise;
      default:  src_pulse = 1'b0;
    endcase
  end

  assign tick = en && src_pulse && (pcnt_q >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      pcnt_q <= '0;
    end else if (!en) begin
      slow_q <= '0;
      pcnt_q <= '0;
    end else begin
      slow_q <= slow_pulse ? '0 : slow_q + 1'b1;
      if (src_pulse) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             restart,
  input  logic             clr,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] step;

  assign step = count + 1'b1;
  assign hit  = tick && !clr && (step == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!en || clr) count <= '0;
    else if (tick)       count <= (hit && restart) ? '0 : step;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_DIV    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cap_pin,
  input  logic             cnt_pin,
  output logic             tmr_out,
  output logic             irq
);
  tmr_mode_t        mode_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] count;
  logic             ev_ref_q;
  logic             ev_cap_q;

  logic wr_mode, wr_ref, wr_evt, cnt_clr;
  logic tick, hit, cap_evt;
  logic cap_lvl, cap_prev, pin_lvl, pin_prev;
  logic cap_rise, cap_fall, pin_rise;

  assign wr_mode = bus_sel && bus_wr && (bus_addr == OFS_MODE);
  assign wr_ref  = bus_sel && bus_wr && (bus_addr == OFS_REF);
  assign cnt_clr = bus_sel && bus_wr && (bus_addr == OFS_CNT);
  assign wr_evt  = bus_sel && bus_wr && (bus_addr == OFS_EVT);

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .level(cap_lvl), .prev(cap_prev)
  );
  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_pin), .level(pin_lvl), .prev(pin_prev)
  );

  assign cap_rise = cap_lvl & ~cap_prev;
  assign cap_fall = ~cap_lvl & cap_prev;
  assign pin_rise = pin_lvl & ~pin_prev;

  tmr_tick_src #(.SLOW_DIV(SLOW_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .en(mode_q.enable), .src(mode_q.src),
    .presc(mode_q.presc), .pin_rise(pin_rise), .tick(tick)
  );

  tmr_count u_cnt (
    .clk(clk), .rst_n(rst_n), .en(mode_q.enable), .tick(tick),
    .restart(mode_q.restart), .clr(cnt_clr), .ref_val(ref_q),
    .count(count), .hit(hit)
  );

  assign cap_evt = mode_q.enable && cap_hit(mode_q.cedge, cap_rise, cap_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= tmr_mode_t'(bus_wdata);
      if (wr_ref)  ref_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_evt) cap_q <= count;
  end

  // a new event in the same cycle as a clearing write keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_ref_q <= 1'b0;
      ev_cap_q <= 1'b0;
    end else begin
      ev_ref_q <= (ev_ref_q & ~(wr_evt & bus_wdata[0])) | hit;
      ev_cap_q <= (ev_cap_q & ~(wr_evt & bus_wdata[1])) | cap_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr_out <= 1'b0;
    else if (mode_q.toggle) tmr_out <= tmr_out ^ hit;
    else                    tmr_out <= hit;
  end

  assign irq = (ev_ref_q & mode_q.ref_ie) | (ev_cap_q & (|mode_q.cedge));

  always_comb begin
    unique case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_REF:  bus_rdata = ref_q;
      OFS_CAP:  bus_rdata = cap_q;
      OFS_CNT:  bus_rdata = count;
      OFS_EVT:  bus_rdata = {{(BUS_W-2){1'b0}}, ev_cap_q, ev_ref_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             restart,
  input logic             toggle,
  input logic [1:0]       src,
  input logic             tick,
  input logic             hit,
  input logic             cap_evt,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_q,
  input logic             ev_ref_q,
  input logic             tmr_out
);
  p_ref_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ev_ref_q);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && restart) |=> (count == '0));

  p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));

  p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !hit) |=> !tmr_out);

  p_capture_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(count)));

  p_src_off_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && src == 2'b00 && !cnt_clr) |=> $stable(count));

  p_tick_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(mode_q.enable), .restart(mode_q.restart),
  .toggle(mode_q.toggle), .src(mode_q.src), .tick(tick), .hit(hit),
  .cap_evt(cap_evt), .cnt_clr(cnt_clr), .count(count), .cap_q(cap_q),
  .ev_ref_q(ev_ref_q), .tmr_out(tmr_out)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        cap_pin = 1'b0;
  logic        cnt_pin = 1'b0;
  logic        tmr_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          q_sel[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];
  event        mon_ev;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cnt_pin(cnt_pin), .tmr_out(tmr_out), .irq(irq)
  );

  function automatic logic [15:0] mk_mode(input int ps, input int ce, input bit tg,
                                          input bit ie, input bit rs, input int src, input bit en);
    logic [15:0] m;
    m = '0;
    m[15:8] = ps[7:0];
    m[7:6]  = ce[1:0];
    m[5]    = tg;
    m[4]    = ie;
    m[3]    = rs;
    m[2:1]  = src[1:0];
    m[0]    = en;
    return m;
  endfunction

  // monitor: pops the expected item and compares it with what the design shows
  initial forever begin
    logic [15:0] act;
    @(mon_ev);
    while (q_sel.size() > 0) begin
      int s; logic [15:0] e; string t;
      s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      act = (s == 0) ? bus_rdata : (s == 1) ? {15'd0, irq} : {15'd0, tmr_out};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", t, act, e);
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [15:0] e, input string t);
    bus_addr = a;
    #1;
    q_sel.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    -> mon_ev;
    #1;
  endtask

  task automatic exp_pin(input int s, input logic e, input string t);
    q_sel.push_back(s); q_exp.push_back({15'd0, e}); q_tag.push_back(t);
    -> mon_ev;
    #1;
  endtask

  task automatic stop_all();
    wr(3'd0, 16'h0000);
    ticks(1);
    wr(3'd4, 16'h0003);
  endtask

  initial begin
    logic [15:0] held;
    ticks(2);
    rst_n = 1'b1;
    ticks(1);
    // R1 reset state
    exp_reg(3'd0, 16'h0000, "R1 mode");
    exp_reg(3'd1, 16'h0000, "R1 ref");
    exp_reg(3'd3, 16'h0000, "R1 count");
    exp_reg(3'd4, 16'h0000, "R1 events");
    exp_pin(1, 1'b0, "R1 irq");
    exp_pin(2, 1'b0, "R1 out");

    // R4 restart, R6 irq, R9 pulse
    wr(3'd1, 16'd5);
    wr(3'd0, mk_mode(1, 0, 0, 1, 1, 1, 1));
    exp_reg(3'd0, mk_mode(1, 0, 0, 1, 1, 1, 1), "R11 mode readback");
    exp_reg(3'd1, 16'd5, "R11 ref readback");
    ticks(3);
    exp_reg(3'd3, 16'd3, "R4 count before match");
    exp_pin(1, 1'b0, "R6 irq before match");
    ticks(2);
    exp_reg(3'd3, 16'd0, "R4 restart to zero");
    exp_reg(3'd4, 16'h0001, "R6 ref flag");
    exp_pin(1, 1'b1, "R6 irq on match");
    exp_pin(2, 1'b1, "R9 pulse high");
    ticks(1);
    exp_pin(2, 1'b0, "R9 pulse one clock");
    exp_reg(3'd3, 16'd1, "R4 counting again");
    wr(3'd0, 16'h0000);
    ticks(1);
    exp_reg(3'd3, 16'd0, "R10 disabled holds zero");
    ticks(3);
    exp_reg(3'd3, 16'd0, "R10 still zero");
    wr(3'd4, 16'h0001);
    exp_reg(3'd4, 16'h0000, "R7 ref flag cleared");
    exp_pin(1, 1'b0, "R7 irq dropped");

    // R2 prescale of 3
    wr(3'd1, 16'd100);
    wr(3'd0, mk_mode(3, 0, 0, 0, 1, 1, 1));
    ticks(2);
    exp_reg(3'd3, 16'd0, "R2 ps3 no step yet");
    ticks(1);
    exp_reg(3'd3, 16'd1, "R2 ps3 first step");
    ticks(2);
    exp_reg(3'd3, 16'd1, "R2 ps3 held");
    ticks(1);
    exp_reg(3'd3, 16'd2, "R2 ps3 second step");
    stop_all();

    // R2 prescale zero = 256
    wr(3'd1, 16'd1000);
    wr(3'd0, mk_mode(0, 0, 0, 0, 1, 1, 1));
    ticks(255);
    exp_reg(3'd3, 16'd0, "R2 ps0 before 256");
    ticks(1);
    exp_reg(3'd3, 16'd1, "R2 ps0 at 256");
    stop_all();

    // R3 slow source
    wr(3'd0, mk_mode(1, 0, 0, 0, 1, 2, 1));
    ticks(15);
    exp_reg(3'd3, 16'd0, "R3 slow before 16");
    ticks(1);
    exp_reg(3'd3, 16'd1, "R3 slow at 16");
    stop_all();

    // R3 external pin source
    wr(3'd0, mk_mode(1, 0, 0, 0, 1, 3, 1));
    ticks(4);
    exp_reg(3'd3, 16'd0, "R3 pin idle");
    for (int i = 0; i < 3; i++) begin
      cnt_pin = 1'b1; ticks(5);
      cnt_pin = 1'b0; ticks(5);
    end
    exp_reg(3'd3, 16'd3, "R3 pin three edges");
    wr(3'd0, mk_mode(1, 0, 0, 0, 1, 0, 1));
    ticks(5);
    exp_reg(3'd3, 16'd3, "R3 source off holds");
    stop_all();

    // R5 free run, R9 toggle, R6 irq masked
    wr(3'd1, 16'd2);
    wr(3'd0, mk_mode(1, 0, 1, 0, 0, 1, 1));
    ticks(2);
    exp_reg(3'd3, 16'd2, "R5 reaches ref");
    exp_reg(3'd4, 16'h0001, "R6 flag with irq masked");
    exp_pin(1, 1'b0, "R6 irq masked");
    exp_pin(2, 1'b1, "R9 toggled high");
    ticks(1);
    exp_reg(3'd3, 16'd3, "R5 passes ref");
    exp_pin(2, 1'b1, "R9 toggle holds");
    wr(3'd4, 16'h0001);
    exp_reg(3'd4, 16'h0000, "R7 clear in free run");
    ticks(65532);
    exp_reg(3'd3, 16'd1, "R5 wrapped");
    exp_pin(2, 1'b1, "R9 no toggle before match");
    ticks(1);
    exp_reg(3'd3, 16'd2, "R5 second match");
    exp_pin(2, 1'b0, "R9 toggled back");
    stop_all();

    // R8 capture, R11 counter clear
    wr(3'd1, 16'h4000);
    wr(3'd0, mk_mode(1, 1, 0, 0, 0, 1, 1));
    ticks(10);
    wr(3'd0, mk_mode(1, 1, 0, 0, 0, 0, 1));
    ticks(1);
    bus_addr = 3'd3; #1;
    held = bus_rdata;
    cap_pin = 1'b1; ticks(5);
    exp_reg(3'd2, held, "R8 rising capture value");
    exp_reg(3'd4, 16'h0002, "R8 cap flag");
    exp_pin(1, 1'b1, "R8 cap irq");
    wr(3'd0, mk_mode(1, 2, 0, 0, 0, 0, 1));
    wr(3'd4, 16'h0002);
    exp_reg(3'd4, 16'h0000, "R7 cap flag cleared");
    cap_pin = 1'b0; ticks(5);
    exp_reg(3'd4, 16'h0002, "R8 falling capture");
    wr(3'd4, 16'h0002);
    cap_pin = 1'b1; ticks(5);
    exp_reg(3'd4, 16'h0000, "R8 rising ignored in falling mode");
    wr(3'd0, mk_mode(1, 0, 0, 0, 0, 0, 1));
    cap_pin = 1'b0; ticks(5);
    exp_reg(3'd4, 16'h0000, "R8 capture off");
    exp_pin(1, 1'b0, "R8 irq off");
    wr(3'd0, mk_mode(1, 3, 0, 0, 0, 0, 1));
    cap_pin = 1'b1; ticks(5);
    exp_reg(3'd4, 16'h0002, "R8 both edges rise");
    wr(3'd4, 16'h0002);
    cap_pin = 1'b0; ticks(5);
    exp_reg(3'd4, 16'h0002, "R8 both edges fall");
    exp_reg(3'd3, held, "R8 count held while stopped");
    wr(3'd3, 16'h0000);
    exp_reg(3'd3, 16'd0, "R11 counter write clears");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule